// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the command side of a four-bank mobile SDRAM model. On every rising clock edge it samples chip select, the row, column and write strobes, a two-bit bank address and a thirteen-bit address. It turns the strobe pattern into one decoded command, which is ACTIVATE, READ, WRITE, single-bank or all-bank PRECHARGE, refresh or mode register load. The decoded command appears on the outputs one edge later, together with the bank and address fields that came with it.

Alongside decoding, the block keeps a per-bank open/idle flag and the row held open in each bank. It follows READ and WRITE bursts so that an auto-precharge request closes its bank when the burst finishes. When clock enable is sampled low, it sorts the low-power state into one of four kinds: precharge power-down, self refresh, active power-down or suspend. The choice depends on whether any bank is open and whether a burst is still running. Commands that would break the bank state are flagged and discarded. Timing checks, the refresh counter and the storage array are not part of this block.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While reset is asserted and right after it, cmdCode is 0 (no operation), illegalCmd is 0, every bit of bankOpen is 0 and powerState is 0 (normal).
- R2: On an edge with clock enable high, the strobes {csN,rasN,casN,weN} decode as follows: 0011 is ACTIVATE (code 1), 0101 is READ (2), 0100 is WRITE (3), 0010 is PRECHARGE (4, or 5 when addr[10] is 1), 0001 is refresh (6) and 0000 is mode register load (7). Any pattern with csN high, and every other pattern, gives no operation (0). The code appears on cmdCode after that edge.
- R3: A legal ACTIVATE sets bankOpen[ba] and stores addr[12:0] as that bank's row in openRows[ba*13 +: 13]. The same edge reports ba on cmdBank and the address on cmdRow.
- R4: READ and WRITE report addr[9:0] on cmdCol and addr[10] on autoPre. Other commands that are not a no operation clear autoPre.
- R5: PRECHARGE with addr[10] at 0 clears only bankOpen[ba]. With addr[10] at 1 it clears every bank, whatever ba holds.
- R6: A mode register load reports the register select (ba) on cmdBank and the opcode (addr) on cmdRow.
- R7: An ACTIVATE to an open bank, or a READ or WRITE to an idle bank, raises illegalCmd for one cycle. It changes neither bankOpen nor openRows, and it starts no burst.
- R8: A legal READ or WRITE starts a burst of BURST_LEN clock-enabled edges. With addr[10] at 1, its bank closes on the BURST_LEN-th clock-enabled edge after the command. A later legal READ or WRITE replaces any burst still running, including its auto-precharge.
- R9: On the first edge that samples clock enable low, powerState becomes one of four codes. It is 4 (suspend) if a burst is running. Otherwise it is 3 (active power-down) if any bank is open. Otherwise it is 2 (self refresh) if the strobes at that edge encode refresh, and 1 (precharge power-down) in all other cases.
- R10: While clock enable is sampled low, commands are ignored. cmdCode is 0, illegalCmd is 0, and bankOpen, openRows, the reported fields, the burst progress and powerState all hold their values.
- R11: The first edge that samples clock enable high sets powerState back to 0, and the command at that edge is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low requests a low-power state |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address / mode register select |
| addr | input | 13 | Row, column, auto-precharge bit and opcode |
| cmdCode | output | 3 | Decoded command of the last sampled edge |
| illegalCmd | output | 1 | One-cycle flag for a command that conflicts with bank state |
| cmdBank | output | 2 | Bank field of the last accepted command |
| cmdRow | output | 13 | Full address field of the last accepted command |
| cmdCol | output | 10 | Column field of the last accepted command |
| autoPre | output | 1 | Auto-precharge request of the last accepted command |
| bankOpen | output | 4 | Per-bank open flag |
| openRows | output | 52 | Open row of each bank, 13 bits per bank |
| powerState | output | 3 | 0 normal, 1 precharge power-down, 2 self refresh, 3 active power-down, 4 suspend |

## Verification
The assertions assume that the strobe and address inputs are stable around each rising edge. They also assume that clock enable is never unknown after reset, because the power-state properties key on its sampled level. The bench drives every input on the falling edge and samples outputs on the next falling edge, so each input is settled a half period before the edge that uses it. It only uses strobe patterns from the defined encoding, plus chip-select-high and one undefined pattern.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ACT     = 3'd1,
    CMD_READ    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_PRE     = 3'd4,
    CMD_PREALL  = 3'd5,
    CMD_REFRESH = 3'd6,
    CMD_MODESET = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    PWR_NORMAL   = 3'd0,
    PWR_PRE_DOWN = 3'd1,
    PWR_SELF_REF = 3'd2,
    PWR_ACT_DOWN = 3'd3,
    PWR_SUSPEND  = 3'd4
  } pwr_e;

  // Strobes from the control path to the bank datapath
  typedef struct packed {
    logic openEn;    // open bank ba, capture its row
    logic closeOne;  // close bank ba
    logic closeAll;  // close every bank
    logic autoClose; // close the bank whose burst just ended
    logic capture;   // latch the command fields
    logic apFlag;    // auto-precharge value to report
  } bank_ctl_t;

  // Strobe order {csN, rasN, casN, weN}
  function automatic cmd_e decode_cmd(input logic [3:0] strobes, input logic apBit);
    unique case (strobes)
      4'b0011: decode_cmd = CMD_ACT;
      4'b0101: decode_cmd = CMD_READ;
      4'b0100: decode_cmd = CMD_WRITE;
      4'b0010: decode_cmd = apBit ? CMD_PREALL : CMD_PRE;
      4'b0001: decode_cmd = CMD_REFRESH;
      4'b0000: decode_cmd = CMD_MODESET;
      default: decode_cmd = CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 apBit,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output bank_ctl_t            ctl,
  output logic [BANK_W-1:0]    autoBank,
  output cmd_e                 cmdCode,
  output logic                 illegalCmd,
  output pwr_e                 powerState
);

  cmd_e             decCmd;
  logic             targetOpen;
  logic             isAccess;
  logic             illegalNow;
  logic             accessGo;
  logic             burstEnd;
  logic [CNT_W-1:0] burstCnt;
  logic             pendAp;
  logic [BANK_W-1:0] pendBank;
  pwr_e             nextPwr;

  always_comb begin
    decCmd     = decode_cmd({csN, rasN, casN, weN}, apBit);
    targetOpen = bankOpen[ba];
    isAccess   = (decCmd == CMD_READ) || (decCmd == CMD_WRITE);
    illegalNow = cke && (((decCmd == CMD_ACT) && targetOpen) ||
                         (isAccess && !targetOpen));
    accessGo   = cke && isAccess && targetOpen;
    burstEnd   = cke && (burstCnt == CNT_W'(1)) && !accessGo;
  end

  always_comb begin
    ctl.openEn    = cke && (decCmd == CMD_ACT) && !targetOpen;
    ctl.closeOne  = cke && (decCmd == CMD_PRE);
    ctl.closeAll  = cke && (decCmd == CMD_PREALL);
    ctl.autoClose = burstEnd && pendAp;
    ctl.capture   = cke && (decCmd != CMD_NOP);
    ctl.apFlag    = isAccess && apBit;
    autoBank      = pendBank;
  end

  // Burst tracking: progress only on clock-enabled edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCnt <= '0;
      pendAp   <= 1'b0;
      pendBank <= '0;
    end else if (accessGo) begin
      burstCnt <= CNT_W'(BURST_LEN);
      pendAp   <= apBit;
      pendBank <= ba;
    end else if (cke && (burstCnt != '0)) begin
      burstCnt <= burstCnt - CNT_W'(1);
      if (burstCnt == CNT_W'(1)) pendAp <= 1'b0;
    end
  end

  // Low-power classification
  always_comb begin
    if (cke)                          nextPwr = PWR_NORMAL;
    else if (powerState != PWR_NORMAL) nextPwr = powerState;
    else if (burstCnt != '0)          nextPwr = PWR_SUSPEND;
    else if (|bankOpen)               nextPwr = PWR_ACT_DOWN;
    else if (decCmd == CMD_REFRESH)   nextPwr = PWR_SELF_REF;
    else                              nextPwr = PWR_PRE_DOWN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerState <= PWR_NORMAL;
      cmdCode    <= CMD_NOP;
      illegalCmd <= 1'b0;
    end else begin
      powerState <= nextPwr;
      cmdCode    <= cke ? decCmd : CMD_NOP;
      illegalCmd <= illegalNow;
    end
  end

  assert_ignore_lowcke_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> (cmdCode == CMD_NOP) && !illegalCmd);

  assert_hold_lowpower_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && (powerState != PWR_NORMAL)) |=> $stable(powerState));

  assert_exit_normal_R11: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> (powerState == PWR_NORMAL));

  assert_suspend_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && (powerState == PWR_NORMAL) && (burstCnt != '0)) |=> (powerState == PWR_SUSPEND));

  assert_burst_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> $stable(burstCnt));

endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bank_ctl_t                  ctl,
  input  logic [BANK_W-1:0]          autoBank,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [ROW_W-1:0]           cmdRow,
  output logic [COL_W-1:0]           cmdCol,
  output logic                       autoPre
);

  logic [NUM_BANKS-1:0] closeHit;
  logic [NUM_BANKS-1:0] openHit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      closeHit[b] = ctl.closeAll ||
                    (ctl.closeOne  && (ba == BANK_W'(b))) ||
                    (ctl.autoClose && (autoBank == BANK_W'(b)));
      openHit[b]  = ctl.openEn && (ba == BANK_W'(b));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[b]                 <= 1'b0;
        openRows[b*ROW_W +: ROW_W]  <= '0;
      end else if (closeHit[b]) begin
        bankOpen[b]                 <= 1'b0;
      end else if (openHit[b]) begin
        bankOpen[b]                 <= 1'b1;
        openRows[b*ROW_W +: ROW_W]  <= addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBank <= '0;
      cmdRow  <= '0;
      cmdCol  <= '0;
      autoPre <= 1'b0;
    end else if (ctl.capture) begin
      cmdBank <= ba;
      cmdRow  <= addr;
      cmdCol  <= addr[COL_W-1:0];
      autoPre <= ctl.apFlag;
    end
  end

  assert_open_clash_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.openEn && bankOpen[ba]));

  assert_open_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.openEn |=> bankOpen[$past(ba)]);

  assert_close_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.closeAll |=> (bankOpen == '0));

  assert_no_capture_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(cmdRow) && $stable(cmdBank));

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [2:0]                 cmdCode,
  output logic                       illegalCmd,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [ROW_W-1:0]           cmdRow,
  output logic [COL_W-1:0]           cmdCol,
  output logic                       autoPre,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [2:0]                 powerState
);

  bank_ctl_t         ctl;
  logic [BANK_W-1:0] autoBank;
  cmd_e              cmdEnum;
  pwr_e              pwrEnum;

  sdram_cmd_ctrl #(
    .BANK_W    (BANK_W),
    .BURST_LEN (BURST_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cke        (cke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ba         (ba),
    .apBit      (addr[AP_BIT]),
    .bankOpen   (bankOpen),
    .ctl        (ctl),
    .autoBank   (autoBank),
    .cmdCode    (cmdEnum),
    .illegalCmd (illegalCmd),
    .powerState (pwrEnum)
  );

  sdram_bank_dp #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .autoBank (autoBank),
    .ba       (ba),
    .addr     (addr),
    .bankOpen (bankOpen),
    .openRows (openRows),
    .cmdBank  (cmdBank),
    .cmdRow   (cmdRow),
    .cmdCol   (cmdCol),
    .autoPre  (autoPre)
  );

  assign cmdCode    = cmdEnum;
  assign powerState = pwrEnum;

endmodule

// File: tb/sdram_cmd_decoder_test.sv
module sdram_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmdCode;
  logic        illegalCmd;
  logic [1:0]  cmdBank;
  logic [12:0] cmdRow;
  logic [9:0]  cmdCol;
  logic        autoPre;
  logic [3:0]  bankOpen;
  logic [51:0] openRows;
  logic [2:0]  powerState;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  sdram_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdCode(cmdCode), .illegalCmd(illegalCmd),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .autoPre(autoPre),
    .bankOpen(bankOpen), .openRows(openRows), .powerState(powerState)
  );

  // Strobe patterns {csN,rasN,casN,weN}
  localparam logic [3:0] S_NOP = 4'b0111, S_ACT = 4'b0011, S_RD = 4'b0101,
                         S_WR = 4'b0100, S_PRE = 4'b0010, S_REF = 4'b0001,
                         S_MRS = 4'b0000;

  // {cke, strobes, ba, addr, expCmd, expIllegal, expOpen, expPower}
  localparam int NVEC = 24;
  localparam logic [30:0] VECS [0:NVEC-1] = '{
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000, 3'd0}, // R2 nop
    {1'b1, 4'b1011, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000, 3'd0}, // R2 masked by csN
    {1'b1, 4'b0011, 2'd1, 13'h1ABC, 3'd1, 1'b0, 4'b0010, 3'd0}, // R3 activate
    {1'b1, 4'b0011, 2'd1, 13'h0000, 3'd1, 1'b1, 4'b0010, 3'd0}, // R7 reactivate
    {1'b1, 4'b0101, 2'd2, 13'h0000, 3'd2, 1'b1, 4'b0010, 3'd0}, // R7 read idle
    {1'b1, 4'b0011, 2'd2, 13'h0055, 3'd1, 1'b0, 4'b0110, 3'd0}, // R3
    {1'b1, 4'b0100, 2'd2, 13'h0003, 3'd3, 1'b0, 4'b0110, 3'd0}, // R2 write
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0110, 3'd0},
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0110, 3'd0},
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0110, 3'd0},
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0110, 3'd0}, // R8 no auto close
    {1'b1, 4'b0010, 2'd1, 13'h0000, 3'd4, 1'b0, 4'b0100, 3'd0}, // R5 single
    {1'b1, 4'b0001, 2'd0, 13'h0000, 3'd6, 1'b0, 4'b0100, 3'd0}, // R2 refresh
    {1'b1, 4'b0011, 2'd0, 13'h0000, 3'd1, 1'b0, 4'b0101, 3'd0},
    {1'b1, 4'b0010, 2'd3, 13'h0400, 3'd5, 1'b0, 4'b0000, 3'd0}, // R5 all banks
    {1'b1, 4'b0000, 2'd2, 13'h0123, 3'd7, 1'b0, 4'b0000, 3'd0}, // R2 mode load
    {1'b0, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000, 3'd1}, // R9 pre power-down
    {1'b0, 4'b0011, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000, 3'd1}, // R10 ignored
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000, 3'd0}, // R11 exit
    {1'b0, 4'b0001, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000, 3'd2}, // R9 self refresh
    {1'b1, 4'b0011, 2'd3, 13'h0000, 3'd1, 1'b0, 4'b1000, 3'd0}, // R11 decoded on exit
    {1'b0, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b1000, 3'd3}, // R9 active power-down
    {1'b1, 4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b1000, 3'd0},
    {1'b1, 4'b0110, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b1000, 3'd0}  // R2 undefined
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return on the next falling edge
  task automatic step(input bit c, input logic [3:0] s, input logic [1:0] b, input logic [12:0] a);
    cke = c;
    {csN, rasN, casN, weN} = s;
    ba = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(1'b1, S_NOP, 2'd0, 13'h0);
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    cke = 1'b1;
    {csN, rasN, casN, weN} = S_NOP;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(cmdCode == 3'd0 && illegalCmd == 1'b0, "R1 reset command", cmdCode, 0);
    check(bankOpen == 4'b0 && powerState == 3'd0, "R1 reset banks/power",
          {bankOpen, powerState}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [30:0] e;
      e = VECS[v];
      step(e[30], e[29:26], e[25:24], e[23:11]);
      check(cmdCode == e[10:8], $sformatf("R2 vector %0d cmdCode", v), cmdCode, e[10:8]);
      check(illegalCmd == e[7], $sformatf("R7 vector %0d illegalCmd", v), illegalCmd, e[7]);
      check(bankOpen == e[6:3], $sformatf("R5 vector %0d bankOpen", v), bankOpen, e[6:3]);
      check(powerState == e[2:0], $sformatf("R9 vector %0d powerState", v), powerState, e[2:0]);
    end

    // Directed tests
    do_reset();
    step(1'b1, S_ACT, 2'd1, 13'h1ABC);
    check(openRows[13 +: 13] == 13'h1ABC, "R3 row stored", openRows[13 +: 13], 13'h1ABC);
    check(cmdBank == 2'd1 && cmdRow == 13'h1ABC, "R3 fields", {cmdBank, cmdRow}, {2'd1, 13'h1ABC});
    step(1'b1, S_ACT, 2'd3, 13'h0F0F);
    step(1'b1, S_ACT, 2'd1, 13'h0001);
    check(illegalCmd == 1'b1, "R7 flag", illegalCmd, 1);
    check(openRows[13 +: 13] == 13'h1ABC, "R7 row kept", openRows[13 +: 13], 13'h1ABC);
    step(1'b1, S_NOP, 2'd0, 13'h0);
    check(illegalCmd == 1'b0, "R7 one cycle", illegalCmd, 0);

    step(1'b1, S_RD, 2'd3, 13'h07A5);
    check(cmdCol == 10'h3A5 && autoPre == 1'b1, "R4 read fields", {autoPre, cmdCol}, {1'b1, 10'h3A5});
    nops(3);
    check(bankOpen[3] == 1'b1, "R8 open before burst end", bankOpen[3], 1);
    nops(1);
    check(bankOpen[3] == 1'b0, "R8 auto close", bankOpen[3], 0);
    check(bankOpen[1] == 1'b1, "R8 other bank kept", bankOpen[1], 1);

    step(1'b1, S_ACT, 2'd3, 13'h0002);
    step(1'b1, S_WR, 2'd3, 13'h0400);
    nops(2);
    step(1'b1, S_WR, 2'd3, 13'h0010);
    check(cmdCol == 10'h010 && autoPre == 1'b0, "R4 write fields", {autoPre, cmdCol}, {1'b0, 10'h010});
    nops(4);
    check(bankOpen[3] == 1'b1, "R8 replaced burst", bankOpen[3], 1);

    step(1'b1, S_RD, 2'd3, 13'h0000);
    step(1'b0, S_NOP, 2'd0, 13'h0);
    check(powerState == 3'd4, "R9 suspend", powerState, 4);
    for (int i = 0; i < 3; i++) step(1'b0, S_ACT, 2'd0, 13'h1FFF);
    check(powerState == 3'd4 && cmdCode == 3'd0, "R10 held", {powerState, cmdCode}, {3'd4, 3'd0});
    check(bankOpen == 4'b1010 && cmdRow == 13'h0000, "R10 ignored", {bankOpen, cmdRow}, {4'b1010, 13'h0});
    step(1'b1, S_NOP, 2'd0, 13'h0);
    check(powerState == 3'd0, "R11 resume", powerState, 0);

    step(1'b1, S_PRE, 2'd1, 13'h0000);
    check(bankOpen == 4'b1000, "R5 single close", bankOpen, 4'b1000);
    step(1'b1, S_MRS, 2'd2, 13'h0033);
    check(cmdCode == 3'd7 && cmdBank == 2'd2 && cmdRow == 13'h0033, "R6 mode load",
          {cmdCode, cmdBank, cmdRow}, {3'd7, 2'd2, 13'h0033});

    do_reset();
    check(bankOpen == 4'b0 && powerState == 3'd0 && autoPre == 1'b0, "R1 mid-run reset",
          {bankOpen, powerState, autoPre}, 0);

    summary();
    $finish;
  end

endmodule